// File: doc/BRIEF.md
# Multi-Lane Micro-op Issue Buffer

This block sits between an instruction translator and a decode stage. The translator turns each complex instruction into up to four micro-ops and hands them over in one cycle as a group. The block writes one micro-op into each of four parallel storage lanes, so that all lanes advance together. Lanes the instruction does not use are filled with a NOP.

On the read side the block gives out one micro-op per cycle. It visits lane 0, then 1, then 2, then 3 of the oldest group. When the micro-op just taken carries the end-of-instruction mark, the rest of that group is thrown away with no lost cycle, and the next output comes from lane 0 of the following group.

A full indication stalls the translator. A flush input, raised on a taken control transfer or an interrupt, empties the buffer at once.

Top module: `uopq_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `in_full` are both 0.
- R2: A group is accepted on a clock edge where `in_valid` is 1, `in_full` is 0 and `flush` is 0. Lane i then stores bits [i*21 +: 21] of `in_uops`, for every lane i up to and including `in_last`.
- R3: Lanes with an index above `in_last` store a NOP: a micro-op of all zeros (opcode field [20:15] equal to 0) with the end mark clear.
- R4: While output is accepted (`out_valid` and `out_ready` both 1), one micro-op leaves per cycle, in the order lane 0, 1, 2, 3 of the oldest group.
- R5: When `in_eoi` is 1, the end mark is stored on lane `in_last` and shows on `out_eoi`. Once that micro-op is accepted, the group is released, and the next output is lane 0 of the next group with no idle cycle.
- R6: When `in_eoi` is 0, all four lanes of the group are output, padding NOPs included.
- R7: `in_full` is 1 exactly when DEPTH groups (default 4) are held. A group offered while `in_full` is 1 is dropped.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_uop` and `out_eoi` hold their values into the next cycle, unless a flush intervenes.
- R9: `flush` forces `out_valid` to 0 in its own cycle. It drops every held group and any group offered in that cycle, and restarts the rotation at lane 0.
- R10: A group accepted into an empty buffer appears on the output in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard everything held; taken branch or interrupt |
| in_valid | input | 1 | Group offered by the translator |
| in_uops | input | 84 | Four 21-bit micro-ops; lane i at [i*21 +: 21] |
| in_last | input | 2 | Index of the last real micro-op in the group |
| in_eoi | input | 1 | Group ends its instruction |
| in_full | output | 1 | No room for another group; translator must stall |
| out_valid | output | 1 | A micro-op is presented |
| out_uop | output | 21 | Presented micro-op; opcode in [20:15] |
| out_eoi | output | 1 | Presented micro-op ends its instruction |
| out_ready | input | 1 | Decode stage accepts the presented micro-op |

## Verification
The bench aims at the following corner cases:
- **End mark on lane 0.** One-micro-op instructions put the end mark on lane 0. A rotor that does not release the group early would output three padding NOPs.
- **No end mark.** Groups without an end mark must show their padding. A design that always skips the padding would lose those slots.
- **Pressure on full.** The buffer is driven to full with `out_ready` low, and groups are offered while full. An overwrite of the oldest group would change the stream. A stalled output that moves would show a different micro-op against the expected head.
- **Flush in busy cycles.** Flushes land in cycles where a push and a pop are both pending. A design that keeps the pushed group, or does not return the rotation to lane 0, would emit stale or misordered micro-ops.

// File: rtl/uopq_pkg.sv
// Shared constants and types for the micro-op issue buffer.
// Assumes a 21-bit micro-op whose top six bits are the opcode.
package uopq_pkg;
    localparam int UOP_W = 21;
    localparam int OPC_W = 6;

    typedef struct packed {
        logic             eoi;
        logic [UOP_W-1:0] uop;
    } slot_t;

    localparam slot_t NOP_SLOT = '0;
endpackage

// File: rtl/uopq_lane.sv
// One storage lane: a small register array written at one index and read at another.
// Assumes the caller handles pointers and occupancy; reads are combinational.
module uopq_lane
    import uopq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  slot_t         wdata,
    input  logic [AW-1:0] raddr,
    output slot_t         rdata
);
    slot_t mem [DEPTH];

    // Store the incoming slot at the write index.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the slot at the read index.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/uopq_rotor.sv
// Lane rotation pointer: steps through lanes 0..LANES-1 on each accepted micro-op.
// Returns to lane 0, and releases the group, on the last lane or on an end mark.
// Assumes fire is never high during flush.
module uopq_rotor #(
    parameter int LANES = 4,
    localparam int LW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fire,
    input  logic          eoi,
    output logic [LW-1:0] ptr,
    output logic          pop
);
    logic [LW-1:0] ptr_q;
    logic          at_end;

    // Detect the end of the current group.
    always_comb begin
        at_end = (ptr_q == LW'(LANES - 1));
        pop    = fire && (eoi || at_end);
        ptr    = ptr_q;
    end

    // Advance or restart the rotation.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  ptr_q <= '0;
        else if (fire)        ptr_q <= pop ? '0 : ptr_q + LW'(1);
    end

    AST_EOI_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fire && eoi |=> ptr_q == '0); // R5
    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !eoi && !at_end && !flush |=> ptr_q == $past(ptr_q) + LW'(1)); // R4
    AST_FLUSH_ROTOR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ptr_q == '0); // R9
endmodule

// File: rtl/uopq_top.sv
// Multi-lane micro-op issue buffer: one group of up to LANES micro-ops in per cycle,
// one micro-op out per cycle in lane order. Padding is skipped after an end mark.
// Assumes in_last < LANES and DEPTH >= 2.
module uopq_top
    import uopq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 4,
    localparam int LW = $clog2(LANES),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   in_valid,
    input  logic [LANES*UOP_W-1:0] in_uops,
    input  logic [LW-1:0]          in_last,
    input  logic                   in_eoi,
    output logic                   in_full,
    output logic                   out_valid,
    output logic [UOP_W-1:0]       out_uop,
    output logic                   out_eoi,
    input  logic                   out_ready
);
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   occ_q;
    logic          push, fire, pop;
    logic [LW-1:0] ptr;
    slot_t         wslot [LANES];
    slot_t         rslot [LANES];
    slot_t         sel;

    // Accept, present and handshake decisions.
    always_comb begin
        in_full   = (occ_q == (AW+1)'(DEPTH));
        push      = in_valid && !in_full && !flush;
        out_valid = (occ_q != '0) && !flush;
        fire      = out_valid && out_ready;
        sel       = rslot[ptr];
        out_uop   = sel.uop;
        out_eoi   = sel.eoi;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Build the slot for lane i: a real micro-op or NOP padding.
        always_comb begin
            if (LW'(i) <= in_last) begin
                wslot[i].uop = in_uops[i*UOP_W +: UOP_W];
                wslot[i].eoi = in_eoi && (LW'(i) == in_last);
            end else begin
                wslot[i] = NOP_SLOT;
            end
        end

        uopq_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .we    (push),
            .waddr (wr_q),
            .wdata (wslot[i]),
            .raddr (rd_q),
            .rdata (rslot[i])
        );
    end

    uopq_rotor #(.LANES(LANES)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .fire  (fire),
        .eoi   (sel.eoi),
        .ptr   (ptr),
        .pop   (pop)
    );

    // Group pointers and occupancy shared by all lanes.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
            occ_q <= occ_q + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= (AW+1)'(DEPTH)); // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_full && !pop |=> in_full || $past(flush)); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> flush || (out_valid && $stable(out_uop) && $stable(out_eoi))); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid && !in_full); // R9
    AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !flush && push |=> out_valid || flush); // R10
endmodule

// File: tb/tb_uopq_top.sv
// Self-checking bench: random groups, handshakes and flushes, plus directed corners.
module tb_uopq_top;
    localparam int W = 21;
    localparam int DEPTH = 4;

    logic          clk = 0, rst_n = 0, flush = 0, in_valid = 0, in_eoi = 0, out_ready = 0;
    logic [4*W-1:0] in_uops = '0;
    logic [1:0]    in_last = '0;
    logic          in_full, out_valid, out_eoi;
    logic [W-1:0]  out_uop;

    int tests = 0, fails = 0, groups = 0;
    bit done = 0;
    logic [22:0] exp_q [$];   // {last_of_group, eoi, uop}

    always #2.5 clk = ~clk;

    uopq_top dut (.clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_uops(in_uops), .in_last(in_last), .in_eoi(in_eoi), .in_full(in_full),
        .out_valid(out_valid), .out_uop(out_uop), .out_eoi(out_eoi), .out_ready(out_ready));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Append the micro-ops a group will emit (R2, R3, R5, R6).
    task automatic model_push(input logic [4*W-1:0] u, input logic [1:0] ll, input logic e);
        for (int j = 0; j < 4; j++) begin
            logic [W-1:0] v;
            logic ee, lst;
            v   = (j <= int'(ll)) ? u[j*W +: W] : '0;
            ee  = e && (j == int'(ll));
            lst = e ? (j == int'(ll)) : (j == 3);
            exp_q.push_back({lst, ee, v});
            if (lst) break;
        end
    endtask

    // One cycle: drive at negedge, check just after, update model.
    task automatic step(input bit v, input logic [4*W-1:0] u, input logic [1:0] ll,
                        input bit e, input bit rdy, input bit fl, input string tag);
        bit full_m, valid_m, fire_m;
        @(negedge clk);
        in_valid = v; in_uops = u; in_last = ll; in_eoi = e; out_ready = rdy; flush = fl;
        #1;
        full_m  = (groups == DEPTH);
        valid_m = (exp_q.size() != 0) && !fl;
        chk(in_full == full_m, {"R7 ", tag}, in_full, full_m);
        chk(out_valid == valid_m, {"R10/R9 ", tag}, out_valid, valid_m);
        if (valid_m) begin
            chk(out_uop == exp_q[0][20:0], {"R4 uop ", tag}, out_uop, exp_q[0][20:0]);
            chk(out_eoi == exp_q[0][21], {"R5 eoi ", tag}, out_eoi, exp_q[0][21]);
        end
        fire_m = valid_m && rdy;
        if (fl) begin
            exp_q.delete();
            groups = 0;
        end else begin
            if (fire_m) begin
                if (exp_q[0][22]) groups--;
                void'(exp_q.pop_front());
            end
            if (v && !full_m) begin
                model_push(u, ll, e);
                groups++;
            end
        end
    endtask

    function automatic logic [4*W-1:0] rnd_uops();
        return {W'($urandom), W'($urandom), W'($urandom), W'($urandom)};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(in_full == 0, "R1 in_full", in_full, 0);
        @(negedge clk);
        rst_n = 1;

        // R5: single micro-op with end mark on lane 0, then a second group back to back.
        step(1, rnd_uops(), 2'd0, 1, 0, 0, "R5 eoi lane0");
        step(1, rnd_uops(), 2'd1, 1, 1, 0, "R5 second");
        repeat (4) step(0, '0, 0, 0, 1, 0, "R5 drain");
        // R6/R3: no end mark, two real micro-ops plus visible padding.
        step(1, rnd_uops(), 2'd1, 0, 1, 0, "R6 pad");
        repeat (5) step(0, '0, 0, 0, 1, 0, "R6 drain");
        // R7/R8: fill with ready low, offer while full.
        repeat (6) step(1, rnd_uops(), 2'd3, 1, 0, 0, "R7 fill");
        repeat (3) step(0, '0, 0, 0, 0, 0, "R8 stall");
        // R9: flush while a push and a pop are both pending.
        step(1, rnd_uops(), 2'd2, 1, 1, 1, "R9 flush");
        step(0, '0, 0, 0, 1, 0, "R9 after");
        step(1, rnd_uops(), 2'd2, 1, 1, 0, "R10 refill");
        step(0, '0, 0, 0, 1, 0, "R10 show");

        // Constrained random mix.
        for (int k = 0; k < 3000; k++) begin
            bit v, e, r, f;
            v = ($urandom % 100) < 55;
            e = ($urandom % 100) < 75;
            r = ($urandom % 100) < 60;
            f = ($urandom % 100) < 3;
            step(v, rnd_uops(), 2'($urandom), e, r, f, "rand R2");
        end
        repeat (20) step(0, '0, 0, 0, 1, 0, "R4 final drain");
        chk(out_valid == 0, "R4 empty at end", out_valid, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule